// File: doc/BRIEF.md
# Section Address Translation Walker

This block turns 32-bit virtual addresses into physical addresses by consulting a flat, single-level table of 4096 one-word section entries kept in memory. Each entry maps one megabyte. For every request the block either finds the entry in a small fully associative lookaside store or fetches it over a read port with a valid/ready handshake. It then returns the physical address together with the cacheable, bufferable and execute-never attributes, or a fault code.

The access-permission and domain checks are made against the current domain-control word each time a response is formed. A table base, a global enable and the domain-control word come from configuration inputs. One request is in flight at a time. A flush pulse empties the lookaside store.

Top module: `section_walker`

## Requirements
- R1: With `cfg_en` low, a request completes one cycle after acceptance with `rsp_pa` equal to `req_va`, all attributes 0 and fault code 0, and no read is issued.
- R2: A table read addresses `{cfg_ttb[31:14], va[31:20], 2'b00}`, so the table base is 16-Kbyte aligned.
- R3: An entry whose bits [1:0] are 2'b10 is a section. A non-faulting response gives `rsp_pa = {entry[31:20], va[19:0]}`, `rsp_cacheable` = entry bit 3, `rsp_bufferable` = entry bit 2, and `rsp_xn` = entry bit 4.
- R4: Entry types 2'b00, 2'b01 and 2'b11 give fault code 2'b01 (translation). Any faulting response has `rsp_pa` and all attributes equal to 0. Fault codes are 00 none, 01 translation, 10 domain, 11 permission. Translation takes priority over domain, and domain takes priority over permission.
- R5: The domain number is entry bits [8:5]. Its mode is `cfg_dacr[2d+1:2d]`. Modes 2'b00 and 2'b10 give fault code 2'b10.
- R6: Mode 2'b11 (manager) skips both the access-permission check and the execute-never check.
- R7: In mode 2'b01 (client), the permission field is entry bits [11:10]. Value 00 faults every access. Value 01 allows only privileged access (`req_priv`=1). Value 10 allows privileged access of any kind and unprivileged reads (`req_write`=0). Value 11 allows every access. A refused access gives fault code 2'b11.
- R8: In client mode, an instruction fetch (`req_fetch`=1) from an entry with bit 4 set gives fault code 2'b11.
- R9: A request whose table index matches a stored entry completes one cycle after acceptance with no read. A request that misses issues exactly one read.
- R10: Only section entries are stored. A request to a non-section entry reads the table again every time.
- R11: The store holds 4 entries and replaces them in round-robin order, so the fifth distinct section evicts the first one.
- R12: A `tlb_flush` pulse invalidates every stored entry.
- R13: The domain and permission checks on a stored entry use the `cfg_dacr` value present when the response is formed.
- R14: `req_ready` is high only while the block is idle, `rsp_valid` is a one-cycle pulse, and `rd_addr` holds steady while `rd_valid` waits for `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Translation enable |
| cfg_ttb | input | 32 | Table base, 16-Kbyte aligned |
| cfg_dacr | input | 32 | Domain modes, 2 bits per domain |
| tlb_flush | input | 1 | Invalidate all stored entries |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 2 | Fault code |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_xn | output | 1 | Execute-never attribute |
| rd_valid | output | 1 | Table read request |
| rd_ready | input | 1 | Table read accepted |
| rd_addr | output | 32 | Table read address |
| rd_rvalid | input | 1 | Table read data present |
| rd_rdata | input | 32 | Table entry word |

## Verification
The assertions assume that `cfg_ttb`, `cfg_en` and `cfg_dacr` stay stable while a request is outstanding. They also assume that memory returns exactly one data beat for each accepted read, and only while the block is waiting for it. The stimulus changes configuration only between requests, when the block is idle. The memory model stalls `rd_ready` periodically and answers each accepted read with a single beat two cycles later. The sweep covers a spread of table indices under two domain-control patterns and every write/fetch/privilege combination.

// File: rtl/section_walker.sv
module section_walker #(
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic [31:0] cfg_ttb,
  input  logic [31:0] cfg_dacr,
  input  logic        tlb_flush,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_fetch,
  input  logic        req_priv,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_fault,
  output logic        rsp_cacheable,
  output logic        rsp_bufferable,
  output logic        rsp_xn,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic        rd_rvalid,
  input  logic [31:0] rd_rdata
);
  localparam int PTR_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WAIT, S_RESP} state_t;

  state_t st_q;
  logic [31:0] va_q, desc_q;
  logic wr_q, fetch_q, priv_q, byp_q;

  logic [11:0] tag_q [TLB_ENTRIES];
  logic [31:0] ent_q [TLB_ENTRIES];
  logic [TLB_ENTRIES-1:0] vld_q, hit_vec;
  logic [PTR_W-1:0] rr_q;
  logic [31:0] hit_desc;

  wire accept = req_valid && req_ready;
  wire fill   = (st_q == S_WAIT) && rd_rvalid && (rd_rdata[1:0] == 2'b10);

  assign req_ready = (st_q == S_IDLE);
  assign rd_valid  = (st_q == S_READ);
  assign rd_addr   = {cfg_ttb[31:14], va_q[31:20], 2'b00};
  assign rsp_valid = (st_q == S_RESP);

  for (genvar i = 0; i < TLB_ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == req_va[31:20]);
  end

  always_comb begin
    hit_desc = '0;
    for (int i = 0; i < TLB_ENTRIES; i++)
      if (hit_vec[i]) hit_desc = hit_desc | ent_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      desc_q  <= '0;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      priv_q  <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          va_q    <= req_va;
          wr_q    <= req_write;
          fetch_q <= req_fetch;
          priv_q  <= req_priv;
          byp_q   <= !cfg_en;
          desc_q  <= hit_desc;
          st_q    <= (!cfg_en || |hit_vec) ? S_RESP : S_READ;
        end
        S_READ: if (rd_ready) st_q <= S_WAIT;
        S_WAIT: if (rd_rvalid) begin
          desc_q <= rd_rdata;
          st_q   <= S_RESP;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        tag_q[i] <= '0;
        ent_q[i] <= '0;
      end
    end else begin
      if (fill) begin
        tag_q[rr_q] <= va_q[31:20];
        ent_q[rr_q] <= rd_rdata;
        vld_q[rr_q] <= 1'b1;
        rr_q <= (rr_q == PTR_W'(TLB_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
      if (tlb_flush) vld_q <= '0;
    end
  end

  wire       is_sec = (desc_q[1:0] == 2'b10);
  wire [1:0] dmode  = cfg_dacr[{desc_q[8:5], 1'b0} +: 2];
  wire [1:0] ap     = desc_q[11:10];
  logic ap_ok;

  always_comb begin
    case (ap)
      2'b00:   ap_ok = 1'b0;
      2'b01:   ap_ok = priv_q;
      2'b10:   ap_ok = priv_q || !wr_q;
      default: ap_ok = 1'b1;
    endcase
  end

  always_comb begin
    if (byp_q)                                         rsp_fault = 2'b00;
    else if (!is_sec)                                  rsp_fault = 2'b01;
    else if (!dmode[0])                                rsp_fault = 2'b10;
    else if (dmode == 2'b01 && (!ap_ok || (fetch_q && desc_q[4])))
                                                       rsp_fault = 2'b11;
    else                                               rsp_fault = 2'b00;
  end

  wire good = !byp_q && (rsp_fault == 2'b00);
  assign rsp_pa         = byp_q ? va_q : (good ? {desc_q[31:20], va_q[19:0]} : 32'h0);
  assign rsp_cacheable  = good && desc_q[3];
  assign rsp_bufferable = good && desc_q[2];
  assign rsp_xn         = good && desc_q[4];

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R14
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  // R1
  bypass_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cfg_en |=> rsp_valid && !rd_valid);
  // R9
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_en && (|hit_vec) |=> rsp_valid && !rd_valid);
  // R11
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R2
  rd_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[31:14] == cfg_ttb[31:14] && rd_addr[1:0] == 2'b00);
endmodule

// File: tb/section_walker_bench.sv
module section_walker_bench;
  localparam logic [31:0] TTB = 32'h0030_C000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_en, tlb_flush, req_valid, req_write, req_fetch, req_priv;
  logic [31:0] cfg_ttb, cfg_dacr, req_va;
  logic req_ready, rsp_valid, rsp_cacheable, rsp_bufferable, rsp_xn, rd_valid;
  logic [31:0] rsp_pa, rd_addr, rd_rdata;
  logic [1:0] rsp_fault;
  logic rd_ready, rd_rvalid;

  section_walker u_section_walker (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ttb(cfg_ttb), .cfg_dacr(cfg_dacr),
    .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_fetch(req_fetch), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable), .rsp_xn(rsp_xn),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata)
  );

  int n_chk = 0, n_bad = 0, reads = 0, tick = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Table: identity over the lower half, bases scrambled over the upper half.
  function automatic logic [31:0] desc_of(input logic [11:0] idx);
    logic [1:0] typ;
    logic [11:0] base;
    if (idx[11:9] == 3'b111)      typ = 2'b00;
    else if (idx[11:9] == 3'b110) typ = idx[0] ? 2'b11 : 2'b01;
    else                          typ = 2'b10;
    base = idx[11] ? (idx ^ 12'h0F0) : idx;
    return {base, 8'h00, idx[8:7], 1'b0, idx[6:3], idx[2], idx[1], idx[0], typ};
  endfunction

  logic pend;
  logic [11:0] pidx, cur_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ready <= 1'b0; rd_rvalid <= 1'b0; pend <= 1'b0; rd_rdata <= '0; pidx <= '0;
    end else begin
      tick++;
      rd_ready  <= (tick % 3) != 0;
      rd_rvalid <= pend;
      pend      <= 1'b0;
      if (pend) rd_rdata <= desc_of(pidx);
      if (rd_valid && rd_ready) begin
        pend <= 1'b1;
        pidx <= rd_addr[13:2];
        reads++;
        chk(rd_addr == {TTB[31:14], cur_idx, 2'b00}, "R2 descriptor address",
            rd_addr, {TTB[31:14], cur_idx, 2'b00});
      end
    end
  end

  logic [11:0] m_tag [4];
  bit m_vld [4];
  int m_ptr = 0;

  task automatic model_flush();
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); tlb_flush = 1'b1;
    @(negedge clk); tlb_flush = 1'b0;
    model_flush();
  endtask

  task automatic do_req(input logic [31:0] va, input bit w, input bit f, input bit p);
    logic [11:0] idx;
    logic [31:0] d, e_pa;
    logic [1:0] e_flt, dm;
    logic [2:0] e_attr;
    bit hit, ap_ok, fast;
    int r0, guard;
    idx = va[31:20];
    d = desc_of(idx);
    hit = 0;
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == idx) hit = 1;
    fast = !cfg_en || hit;
    // R4 R5 R6 R7 R8: expected fault code and priority
    dm = cfg_dacr[2*d[8:5] +: 2];
    case (d[11:10])
      2'b00: ap_ok = 0;
      2'b01: ap_ok = p;
      2'b10: ap_ok = p || !w;
      default: ap_ok = 1;
    endcase
    if (!cfg_en) e_flt = 2'b00;
    else if (d[1:0] != 2'b10) e_flt = 2'b01;
    else if (dm == 2'b00 || dm == 2'b10) e_flt = 2'b10;
    else if (dm == 2'b01 && (!ap_ok || (f && d[4]))) e_flt = 2'b11;
    else e_flt = 2'b00;
    // R1 R3
    if (!cfg_en) begin e_pa = va; e_attr = 3'b000; end
    else if (e_flt != 2'b00) begin e_pa = 32'h0; e_attr = 3'b000; end
    else begin e_pa = {d[31:20], va[19:0]}; e_attr = {d[3], d[2], d[4]}; end

    cur_idx = idx;
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = w; req_fetch = f; req_priv = p;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R14 busy after accept", {31'd0, req_ready}, 32'd0);
    chk(rsp_valid == fast, fast ? "R9 one-cycle response" : "R9 miss waits for read",
        {31'd0, rsp_valid}, {31'd0, fast});
    guard = 0;
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    chk(rsp_pa == e_pa, cfg_en ? "R3 physical address" : "R1 bypass address", rsp_pa, e_pa);
    chk(rsp_fault == e_flt, "R4 R5 R6 R7 R8 fault code", {30'd0, rsp_fault}, {30'd0, e_flt});
    chk({rsp_cacheable, rsp_bufferable, rsp_xn} == e_attr, "R3 attributes",
        {29'd0, rsp_cacheable, rsp_bufferable, rsp_xn}, {29'd0, e_attr});
    chk(reads - r0 == (fast ? 0 : 1), cfg_en ? "R10 reads per lookup" : "R1 no read when disabled",
        reads - r0, fast ? 0 : 1);
    if (cfg_en && !hit && d[1:0] == 2'b10) begin
      m_tag[m_ptr] = idx; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % 4;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R14 single response pulse",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic sweep(input int step, input int start);
    for (int i = start; i < 4096; i += step) begin
      for (int c = 0; c < 8; c++)
        do_req({12'(i), 20'(i * 7919 + c)}, c[0], c[1], c[2]);
    end
  endtask

  task automatic run_all();
    int r0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_ttb = TTB; cfg_dacr = 32'hE4E4_E4E4;
    tlb_flush = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 0; req_fetch = 0; req_priv = 0;
    model_flush();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !rd_valid, "R14 reset state",
        {29'd0, req_ready, rsp_valid, rd_valid}, 32'd4);

    // R1
    for (int i = 0; i < 8; i++) do_req(32'h1357_9BDF * (i + 1), i[0], i[1], i[2]);

    cfg_en = 1'b1;
    sweep(13, 0);
    do_flush();
    cfg_dacr = 32'h1B1B_1B1B;
    sweep(29, 5);

    // R13: a stored client entry with permission 00 becomes reachable as manager
    do_flush();
    cfg_dacr = 32'h0000_0001;
    do_req(32'h0050_1234, 0, 0, 1);
    chk(rsp_fault == 2'b11, "R7 client permission 00 faults", {30'd0, rsp_fault}, 32'd3);
    cfg_dacr = 32'hFFFF_FFFF;
    r0 = reads;
    do_req(32'h0050_1234, 1, 1, 0);
    chk(rsp_fault == 2'b00 && reads == r0, "R13 live domain check on stored entry",
        {30'd0, rsp_fault}, 32'd0);

    // R12
    do_flush();
    r0 = reads;
    do_req(32'h2000_0040, 0, 0, 1);
    do_req(32'h2000_0080, 0, 0, 1);
    do_flush();
    do_req(32'h2000_00C0, 0, 0, 1);
    chk(reads - r0 == 2, "R12 flush forces a re-read", reads - r0, 2);

    // R11
    do_flush();
    for (int i = 0; i < 5; i++) do_req({12'h100 + 12'(i), 20'h0}, 0, 0, 1);
    r0 = reads;
    do_req(32'h1000_0000, 0, 0, 1);
    chk(reads - r0 == 1, "R11 oldest entry evicted", reads - r0, 1);
    r0 = reads;
    do_req(32'h1040_0000, 0, 0, 1);
    chk(reads - r0 == 0, "R11 newest entry kept", reads - r0, 0);

    // R10
    r0 = reads;
    do_req(32'hE010_0000, 0, 0, 1);
    do_req(32'hE010_0000, 0, 0, 1);
    chk(reads - r0 == 2, "R10 non-section never stored", reads - r0, 2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule